// File: doc/BRIEF.md
# Event Timer with Single Comparator Channel

This block is a free-running 64-bit up counter with one comparator channel. Software reaches it through a small 32-bit register bus made of an address, a write enable, write data and read data. A write is accepted on the clock edge where the write enable is high. Read data is combinational from the address, so it reflects register state in the same cycle as the access. Every register is 64 bits wide and occupies two 32-bit words, with the low word at the lower address.

When the counter equals the comparator, the channel raises its interrupt on `irq_out`. In edge mode this is a one-clock pulse. In level mode it is a status flag that holds until software clears it. The channel runs either one-shot, or periodic, where the comparator advances by a stored reload period on every match. A 32-bit mode limits the comparison to the low words. The 5-bit route field is stored and read back but drives nothing.

Register map (byte offsets): capabilities 0x000/0x004, global configuration 0x010, interrupt status 0x020, counter 0x0F0/0x0F4, channel configuration 0x100, comparator 0x108/0x10C. Upper words of global configuration, status and channel configuration read zero.

Top module: `evt_timer`

## Requirements
- R1: Each register is reached as two 32-bit words, low word at the lower offset; reads of unmapped offsets (for example 0x200) return zero.
- R2: The capability register is read-only. The high word (0x004) is the tick period in femtoseconds. The low word (0x000) reads 0x2001: bits 7:0 revision 0x01, bits 12:8 timer count minus one (0), bit 13 set for a 64-bit counter. Writes to it change nothing.
- R3: Global configuration bit 0 enables counting. While it is clear, the counter holds and no interrupt or status is raised, even when counter equals comparator. Bit 1 is stored and read back with no effect.
- R4: While enabled, the counter advances by one per clock. Each counter word (0x0F0, 0x0F4) is writable, and a write takes precedence over the increment.
- R5: A read of a counter word returns its value in the cycle of that access. A high, low, high read sequence that crosses a carry out of the low word shows two different high words, and the software retries.
- R6: In one-shot mode (channel configuration bit 3 = 0), a match fires when the counter equals the comparator. `irq_out` rises in the cycle after the match, when the counter reads match+1. There is no further firing as the counter moves on.
- R7: In periodic mode (bit 3 = 1), each match advances the comparator by the reload period. This yields one interrupt per period with no software reload.
- R8: Channel configuration bit 6 is the value-set control. In periodic mode, a comparator word write made while it is set also loads the same word of the reload period. A write to the low comparator word clears bit 6.
- R9: With level trigger (bit 1 = 1), a match sets status bit 0 at 0x020 and `irq_out` follows that bit. Writing 1 to it clears it; writing 0 has no effect.
- R10: With edge trigger (bit 1 = 0), each match gives a one-clock pulse on `irq_out` and the status bit stays clear.
- R11: With interrupt enable (bit 2) clear, a match raises neither `irq_out` nor status.
- R12: With 32-bit mode (bit 8) set, only the low 32 bits of counter and comparator are compared, and writes to the upper comparator word (0x10C) are dropped.
- R13: Channel configuration bits 4 and 5 read as 1, and bits 13:9 store a route number that reads back. After reset, channel configuration reads 0x30, the comparator reads all ones, and the counter and global configuration read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address of a 32-bit word |
| bus_we | input | 1 | Write strobe, accepted on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_out | output | 1 | Channel interrupt (pulse or level) |

## Verification
The hardest situation to reach is a split counter read that straddles the carry out of the low word. A single-word read never shows it, and it needs the low word within a few counts of wrapping. The stimulus stops the counter and writes a low word eight below the wrap. It then enables counting and issues back-to-back high, low, high reads one cycle apart. This alignment puts the carry inside the third triple, so the bench expects exactly one retry and a clean value after it. Periodic pulse spacing is checked the same way, by sampling the counter in the cycle each pulse is seen.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = 64;
   localparam int unsigned NW     = CNT_W / WORD_W;

   // word offsets
   localparam logic [11:0] OFS_CAP_LO = 12'h000;
   localparam logic [11:0] OFS_CAP_HI = 12'h004;
   localparam logic [11:0] OFS_GCFG   = 12'h010;
   localparam logic [11:0] OFS_GSTS   = 12'h020;
   localparam logic [11:0] OFS_CNT_LO = 12'h0F0;
   localparam logic [11:0] OFS_CNT_HI = 12'h0F4;
   localparam logic [11:0] OFS_TCFG   = 12'h100;
   localparam logic [11:0] OFS_CMP_LO = 12'h108;
   localparam logic [11:0] OFS_CMP_HI = 12'h10C;

   // channel configuration bit positions
   localparam int unsigned TB_LEVEL  = 1;
   localparam int unsigned TB_IEN    = 2;
   localparam int unsigned TB_PER    = 3;
   localparam int unsigned TB_VSET   = 6;
   localparam int unsigned TB_M32    = 8;
   localparam int unsigned TB_ROUTE  = 9;

   typedef struct packed {
      logic gcfg;
      logic sts;
      logic cnt_lo;
      logic cnt_hi;
      logic tcfg;
      logic cmp_lo;
      logic cmp_hi;
   } wstb_t;

   typedef struct packed {
      logic [4:0] route;
      logic       mode32;
      logic       valset;
      logic       periodic;
      logic       ien;
      logic       level;
   } tcfg_t;
endpackage

// File: rtl/evt_regbus.sv
module evt_regbus
   import evt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
   parameter logic [7:0]  REV_ID    = 8'h01
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              gen_en,
   input  logic              gen_leg,
   input  logic              sts,
   input  tcfg_t             cfg,
   input  logic [CNT_W-1:0]  cmp,
   output wstb_t             wr,
   output logic [31:0]       rdata
);
   localparam logic [31:0] CAP_LO_VAL = {18'b0, 1'b1, 5'd0, REV_ID};

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_comb begin
      wr.gcfg   = we & hit(addr, OFS_GCFG);
      wr.sts    = we & hit(addr, OFS_GSTS);
      wr.cnt_lo = we & hit(addr, OFS_CNT_LO);
      wr.cnt_hi = we & hit(addr, OFS_CNT_HI);
      wr.tcfg   = we & hit(addr, OFS_TCFG);
      wr.cmp_lo = we & hit(addr, OFS_CMP_LO);
      wr.cmp_hi = we & hit(addr, OFS_CMP_HI);
   end

   always_comb begin
      rdata = '0;
      if (hit(addr, OFS_CAP_LO)) rdata = CAP_LO_VAL;
      if (hit(addr, OFS_CAP_HI)) rdata = PERIOD_FS;
      if (hit(addr, OFS_GCFG))   rdata = {30'b0, gen_leg, gen_en};
      if (hit(addr, OFS_GSTS))   rdata = {31'b0, sts};
      if (hit(addr, OFS_CNT_LO)) rdata = cnt[31:0];
      if (hit(addr, OFS_CNT_HI)) rdata = cnt[63:32];
      if (hit(addr, OFS_TCFG))
         rdata = {18'b0, cfg.route, cfg.mode32, 1'b0, cfg.valset, 2'b11,
                  cfg.periodic, cfg.ien, cfg.level, 1'b0};
      if (hit(addr, OFS_CMP_LO)) rdata = cmp[31:0];
      if (hit(addr, OFS_CMP_HI)) rdata = cmp[63:32];
   end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
   import evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_gcfg,
   input  logic [NW-1:0]    wr_cnt,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             gen_en,
   output logic             gen_leg
);
   logic [CNT_W-1:0] inc;
   logic [CNT_W-1:0] cnt_d;

   assign inc = gen_en ? cnt + CNT_W'(1) : cnt;

   genvar w;
   for (w = 0; w < NW; w++) begin : g_word
      assign cnt_d[w*WORD_W +: WORD_W] = wr_cnt[w] ? wdata : inc[w*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         gen_en  <= 1'b0;
         gen_leg <= 1'b0;
      end else begin
         cnt <= cnt_d;
         if (wr_gcfg) begin
            gen_en  <= wdata[0];
            gen_leg <= wdata[1];
         end
      end
   end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
   import evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_cfg,
   input  logic [NW-1:0]    wr_cmp,
   input  logic             wr_sts,
   input  logic [31:0]      wdata,
   output tcfg_t            cfg,
   output logic [CNT_W-1:0] cmp,
   output logic             sts,
   output logic             match,
   output logic             irq
);
   logic [CNT_W-1:0] per, cmp_d, per_d, adv;
   logic             pulse_q, fire, hit_lo, hit_all;

   assign hit_lo  = cnt[WORD_W-1:0] == cmp[WORD_W-1:0];
   assign hit_all = cnt == cmp;
   assign match   = gen_en & (cfg.mode32 ? hit_lo : hit_all);
   assign fire    = match & cfg.ien;
   assign adv     = cmp + per;

   genvar w;
   for (w = 0; w < NW; w++) begin : g_word
      logic        upper_blk;
      logic        wr_ok;
      logic [31:0] adv_w;
      assign upper_blk = cfg.mode32 & (w != 0);
      assign wr_ok     = wr_cmp[w] & ~upper_blk;
      assign adv_w     = upper_blk ? cmp[w*WORD_W +: WORD_W] : adv[w*WORD_W +: WORD_W];
      assign cmp_d[w*WORD_W +: WORD_W] = wr_ok ? wdata
                                       : (match & cfg.periodic) ? adv_w
                                       : cmp[w*WORD_W +: WORD_W];
      assign per_d[w*WORD_W +: WORD_W] = (wr_ok & cfg.periodic & cfg.valset) ? wdata
                                       : per[w*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp     <= '1;
         per     <= '0;
         cfg     <= '0;
         sts     <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         cmp <= cmp_d;
         per <= per_d;
         if (wr_cfg) begin
            cfg.route    <= wdata[TB_ROUTE +: 5];
            cfg.mode32   <= wdata[TB_M32];
            cfg.valset   <= wdata[TB_VSET];
            cfg.periodic <= wdata[TB_PER];
            cfg.ien      <= wdata[TB_IEN];
            cfg.level    <= wdata[TB_LEVEL];
         end else if (wr_cmp[0]) begin
            cfg.valset <= 1'b0;
         end
         if (fire & cfg.level)       sts <= 1'b1;
         else if (wr_sts & wdata[0]) sts <= 1'b0;
         pulse_q <= fire & ~cfg.level;
      end
   end

   assign irq = cfg.level ? sts : pulse_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
   parameter logic [7:0]  REV_ID    = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);
   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("evt_timer: ADDR_W must be 9..16");
   end
   if (PERIOD_FS == 32'd0 || PERIOD_FS > 32'd100_000_000) begin : g_bad_period
      $error("evt_timer: PERIOD_FS must be 1..100000000");
   end

   wstb_t            wr;
   tcfg_t            cfg;
   logic [CNT_W-1:0] cnt, cmp;
   logic             gen_en, gen_leg, sts, match;
   logic [NW-1:0]    wr_cnt, wr_cmp;

   assign wr_cnt = {wr.cnt_hi, wr.cnt_lo};
   assign wr_cmp = {wr.cmp_hi, wr.cmp_lo};

   evt_regbus #(.ADDR_W(ADDR_W), .PERIOD_FS(PERIOD_FS), .REV_ID(REV_ID)) u_bus (
      .addr(bus_addr), .we(bus_we), .cnt(cnt), .gen_en(gen_en), .gen_leg(gen_leg),
      .sts(sts), .cfg(cfg), .cmp(cmp), .wr(wr), .rdata(bus_rdata));

   evt_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_gcfg(wr.gcfg), .wr_cnt(wr_cnt),
      .wdata(bus_wdata), .cnt(cnt), .gen_en(gen_en), .gen_leg(gen_leg));

   evt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cnt(cnt), .wr_cfg(wr.tcfg),
      .wr_cmp(wr_cmp), .wr_sts(wr.sts), .wdata(bus_wdata), .cfg(cfg), .cmp(cmp),
      .sts(sts), .match(match), .irq(irq_out));
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        gen_en,
   input logic [1:0]  wr_cnt,
   input logic [63:0] cnt,
   input logic        irq_out,
   input logic        match,
   input logic        level,
   input logic        sts,
   input logic        wr_sts,
   input logic [31:0] wdata,
   input logic [1:0]  wr_cmp,
   input logic        mode32,
   input logic        valset,
   input logic [31:0] cmp_hi
);
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && wr_cnt == 2'b00) |=> cnt == $past(cnt) + 64'd1);

   p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en && wr_cnt == 2'b00) |=> $stable(cnt));

   p_edge_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!level && irq_out) |-> $past(match));

   p_w1c_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts) |-> $past(wr_sts && wdata[0]));

   p_valset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp[0] |=> !valset);

   p_upper_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode32 && wr_cmp[1]) |=> $stable(cmp_hi));
endmodule

bind evt_timer evt_timer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .wr_cnt(wr_cnt), .cnt(cnt),
   .irq_out(irq_out), .match(match), .level(cfg.level), .sts(sts),
   .wr_sts(wr.sts), .wdata(bus_wdata), .wr_cmp(wr_cmp), .mode32(cfg.mode32),
   .valset(cfg.valset), .cmp_hi(cmp[63:32]));

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
   localparam logic [31:0] PFS = 32'd10_000_000;
   localparam logic [11:0] A_CAPL = 12'h000, A_CAPH = 12'h004, A_GCFG = 12'h010,
                           A_STS = 12'h020, A_CNTL = 12'h0F0, A_CNTH = 12'h0F4,
                           A_TCFG = 12'h100, A_CMPL = 12'h108, A_CMPH = 12'h10C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   evt_timer #(.PERIOD_FS(PFS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd32(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic park(input logic [31:0] cfg, input logic [31:0] clo, input logic [31:0] chi);
      wr32(A_GCFG, 32'h0);
      wr32(A_CNTH, chi);
      wr32(A_CNTL, clo);
      wr32(A_TCFG, cfg);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R6 irq low after reset", {63'b0, irq_out}, 64'd0);
      rd32(A_CAPL, d); check("R2 cap low", {32'b0, d}, 64'h2001);
      rd32(A_CAPH, d); check("R2 cap period", {32'b0, d}, {32'b0, PFS});
      rd32(A_TCFG, d); check("R13 cfg reset", {32'b0, d}, 64'h30);
      rd32(A_CMPL, d); check("R13 cmp low reset", {32'b0, d}, 64'hFFFF_FFFF);
      rd32(A_CMPH, d); check("R13 cmp high reset", {32'b0, d}, 64'hFFFF_FFFF);
      rd32(A_GCFG, d); check("R13 gcfg reset", {32'b0, d}, 64'h0);
      rd32(A_CNTL, d); check("R13 counter reset", {32'b0, d}, 64'h0);
      wr32(A_CAPL, 32'hFFFF_FFFF);
      rd32(A_CAPL, d); check("R2 cap write ignored", {32'b0, d}, 64'h2001);
      rd32(12'h200, d); check("R1 unmapped reads zero", {32'b0, d}, 64'h0);
      wr32(A_TCFG, 32'h3E00);
      rd32(A_TCFG, d); check("R13 route readback", {32'b0, d}, 64'h3E30);
      wr32(A_TCFG, 32'h0);
   endtask

   task automatic t_global_off();
      logic [31:0] d;
      park(32'h6, 32'h55, 32'h0);
      wr32(A_CMPH, 32'h0);
      wr32(A_CMPL, 32'h55);
      wr32(A_GCFG, 32'h2);
      rd32(A_GCFG, d); check("R3 legacy bit stored", {32'b0, d}, 64'h2);
      repeat (10) @(negedge clk);
      rd32(A_CNTL, d); check("R3 counter holds when off", {32'b0, d}, 64'h55);
      rd32(A_CNTH, d); check("R1 counter high word", {32'b0, d}, 64'h0);
      check("R3 no irq when off", {63'b0, irq_out}, 64'd0);
      rd32(A_STS, d); check("R3 no status when off", {32'b0, d}, 64'h0);
   endtask

   task automatic t_count_step();
      logic [31:0] a, b;
      park(32'h0, 32'd100, 32'h0);
      wr32(A_GCFG, 32'h1);
      rd32(A_CNTL, a);
      rd32(A_CNTL, b);
      check("R4 step of one", {32'b0, b}, {32'b0, a} + 64'd1);
      wr32(A_CNTH, 32'h7);
      rd32(A_CNTH, a); check("R4 write while counting", {32'b0, a}, 64'h7);
   endtask

   task automatic t_oneshot_level();
      logic [31:0] d, cv;
      bit got = 1'b0, refire = 1'b0;
      park(32'h6, 32'h0, 32'h0);
      wr32(A_CMPH, 32'h0);
      wr32(A_CMPL, 32'd20);
      wr32(A_GCFG, 32'h1);
      bus_addr = A_CNTL;
      cv = '0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); #1;
         if (irq_out) begin got = 1'b1; cv = bus_rdata; break; end
      end
      check("R6 one-shot fired", {63'b0, got}, 64'd1);
      check("R6 irq cycle after match", {32'b0, cv}, 64'd21);
      repeat (5) @(negedge clk);
      check("R9 level holds", {63'b0, irq_out}, 64'd1);
      rd32(A_STS, d); check("R9 status set", {32'b0, d}, 64'h1);
      wr32(A_STS, 32'h0);
      #1 check("R9 write zero no effect", {63'b0, irq_out}, 64'd1);
      wr32(A_STS, 32'h1);
      #1 check("R9 write one clears", {63'b0, irq_out}, 64'd0);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #1;
         if (irq_out) refire = 1'b1;
      end
      check("R6 no refire", {63'b0, refire}, 64'd0);
   endtask

   task automatic t_periodic_edge();
      logic [31:0] d;
      logic [31:0] vals [3];
      int k = 0;
      park(32'h4C, 32'h0, 32'h0);
      wr32(A_CMPH, 32'h0);
      wr32(A_CMPL, 32'd10);
      rd32(A_TCFG, d); check("R8 value-set self clears", {32'b0, d}, 64'h3C);
      wr32(A_GCFG, 32'h1);
      bus_addr = A_CNTL;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #1;
         if (irq_out) begin
            if (k < 3) vals[k] = bus_rdata;
            k++;
         end
      end
      check("R10 pulse count one clock each", 64'(k), 64'd3);
      check("R7 first pulse", {32'b0, vals[0]}, 64'd11);
      check("R7 second pulse period", {32'b0, vals[1]}, 64'd21);
      check("R8 reload from value-set write", {32'b0, vals[2]}, 64'd31);
      rd32(A_STS, d); check("R10 status stays clear", {32'b0, d}, 64'h0);
   endtask

   task automatic t_ien_off();
      logic [31:0] d;
      bit seen = 1'b0;
      park(32'h2, 32'h0, 32'h0);
      wr32(A_CMPH, 32'h0);
      wr32(A_CMPL, 32'd5);
      wr32(A_GCFG, 32'h1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (irq_out) seen = 1'b1;
      end
      check("R11 no irq when disabled", {63'b0, seen}, 64'd0);
      rd32(A_STS, d); check("R11 no status when disabled", {32'b0, d}, 64'h0);
   endtask

   task automatic t_mode32();
      logic [31:0] d, cv;
      bit got = 1'b0;
      park(32'h106, 32'h0, 32'h5);
      wr32(A_CMPH, 32'h7);
      rd32(A_CMPH, d); check("R12 upper comparator write dropped", {32'b0, d}, 64'h0);
      wr32(A_CMPL, 32'd15);
      wr32(A_GCFG, 32'h1);
      bus_addr = A_CNTL;
      cv = '0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk); #1;
         if (irq_out) begin got = 1'b1; cv = bus_rdata; break; end
      end
      check("R12 low-word match fires", {63'b0, got}, 64'd1);
      check("R12 match on low bits", {32'b0, cv}, 64'd16);
      wr32(A_STS, 32'h1);
   endtask

   task automatic t_carry();
      logic [31:0] h1, lo, h2;
      int retries = 0;
      bit ok = 1'b0;
      park(32'h0, 32'hFFFF_FFF8, 32'h3);
      wr32(A_GCFG, 32'h1);
      for (int i = 0; i < 8 && !ok; i++) begin
         rd32(A_CNTH, h1);
         rd32(A_CNTL, lo);
         rd32(A_CNTH, h2);
         if (h1 != h2) retries++;
         else begin
            n_chk++;
            if (!((h1 == 32'h3 && lo >= 32'hFFFF_FFF8) || (h1 == 32'h4 && lo < 32'h40))) begin
               n_bad++;
               $display("FAIL R5 split read actual=%0h_%0h expected=near 3_ffffffff", h1, lo);
            end
            if (h1 == 32'h4) ok = 1'b1;
         end
      end
      check("R5 carry seen once as retry", 64'(retries), 64'd1);
      check("R5 reached upper word 4", {63'b0, ok}, 64'd1);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_global_off();
      t_count_step();
      t_oneshot_level();
      t_periodic_edge();
      t_ien_off();
      t_mode32();
      t_carry();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule